// File: doc/BRIEF.md
# Floating-Point Exception Latch, Mask and Status Unit

This unit tracks six classes of floating-point exception for an arithmetic coprocessor driven by a micro-sequencer. While an instruction runs, the sequencer pulses one set input per class. Each pulse sets a transient per-instruction latch. A control register holds one mask bit per class. A status register holds one sticky flag per class.

The unit merges the latches with the masks and the present status flags to find exceptions that are both new and unmasked. It reports such an event to the sequencer in the same cycle, so a routine can stop early, and it raises an interrupt request to the host processor. When the instruction ends, the latches are ORed into the status flags. When the next instruction starts, the latches are cleared. Status flags leave the register only through an explicit clear command.

Class bit positions in every six-bit vector: bit 0 invalid operation, bit 1 denormalized operand, bit 2 zero divide, bit 3 overflow, bit 4 underflow, bit 5 precision.

Top module: `fpx_exc_unit`

## Requirements
- R1: After reset, mask_o is 6'h3F (every class masked), status_o is 0, and irq_o and unmasked_o are low.
- R2: A pulse on bit k of exc_set_i latches class k until the next instruction start. The latch is observable through the status commit and through unmasked_o.
- R3: unmasked_o is high in the same cycle as a set pulse, and in every following cycle while the latch holds, for any class whose mask bit is 0 and whose status flag is 0.
- R4: A class whose mask bit is 1 never drives unmasked_o and never raises irq_o.
- R5: A class whose status flag is already 1 is not new. Latching it again drives neither unmasked_o nor a new interrupt.
- R6: A cycle with instr_end_i high ORs the latches, including any set pulse in that cycle, into status_o, visible on the next cycle.
- R7: A cycle with instr_start_i high clears every latch. A set pulse in that same cycle is still latched.
- R8: Status flags are sticky and are removed only by status_clr_i, which zeroes status_o on the next cycle. The clear wins over a commit in the same cycle.
- R9: irq_o rises on the cycle after unmasked_o is high. It stays high until status_clr_i, and it is low while every class that raised it is masked.
- R10: A cycle with ctrl_we_i high loads ctrl_mask_i into the mask register, visible on mask_o on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exc_set_i | input | 6 | Per-class set pulses from the sequencer |
| instr_start_i | input | 1 | Instruction start strobe; clears latches |
| instr_end_i | input | 1 | Instruction end strobe; commits latches into status |
| ctrl_we_i | input | 1 | Mask register write enable |
| ctrl_mask_i | input | 6 | Mask value to write |
| status_clr_i | input | 1 | Clear all status flags and pending interrupt |
| mask_o | output | 6 | Current mask register |
| status_o | output | 6 | Current sticky status flags |
| unmasked_o | output | 1 | New unmasked exception seen this cycle (combinational) |
| irq_o | output | 1 | Interrupt request to the host |

## Verification
The assertions check the cycle-level invariants on every cycle. These are: the interrupt follows an unmasked event by one cycle, it is never high with all classes masked, status flags never drop without a clear, a clear empties status, and a mask write lands one cycle later. Other behaviours need a whole instruction of context, and only the bench's scenarios can show them. These are: latches dropped at instruction start while a coincident pulse survives, a flag already in status suppressing a repeat event, the clear winning over a commit, and the interrupt returning when a mask bit is cleared again.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int unsigned NUM_CLS = 6;

  typedef enum int unsigned {
    CLS_INVALID = 0,
    CLS_DENORM  = 1,
    CLS_ZDIV    = 2,
    CLS_OVFL    = 3,
    CLS_UNFL    = 4,
    CLS_PREC    = 5
  } cls_e;

  typedef logic [NUM_CLS-1:0] cls_vec_t;
endpackage

// File: rtl/fpx_latch_bank.sv
module fpx_latch_bank #(
  parameter int unsigned N_CLS = fpx_pkg::NUM_CLS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CLS-1:0] set_i,
  input  logic             start_i,
  output logic [N_CLS-1:0] live_o
);
  logic [N_CLS-1:0] lat_q;

  for (genvar g = 0; g < N_CLS; g++) begin : g_lat
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     lat_q[g] <= 1'b0;
      else if (start_i || set_i[g])    lat_q[g] <= set_i[g];
    end
  end

  // held latches plus this cycle's pulses, for same-cycle reporting
  assign live_o = lat_q | set_i;
endmodule

// File: rtl/fpx_ctrl_status.sv
module fpx_ctrl_status #(
  parameter int unsigned     N_CLS    = fpx_pkg::NUM_CLS,
  parameter logic [N_CLS-1:0] MASK_RST = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [N_CLS-1:0] mask_i,
  input  logic             commit_i,
  input  logic [N_CLS-1:0] commit_vec_i,
  input  logic             clr_i,
  output logic [N_CLS-1:0] mask_o,
  output logic [N_CLS-1:0] status_o
);
  logic [N_CLS-1:0] mask_q, status_q, status_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= MASK_RST;
    else if (we_i) mask_q <= mask_i;
  end

  always_comb begin
    status_d = status_q;
    if (clr_i)         status_d = '0;
    else if (commit_i) status_d = status_q | commit_vec_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= status_d;
  end

  assign mask_o   = mask_q;
  assign status_o = status_q;
endmodule

// File: rtl/fpx_irq_gen.sv
module fpx_irq_gen #(
  parameter int unsigned N_CLS = fpx_pkg::NUM_CLS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CLS-1:0] live_i,
  input  logic [N_CLS-1:0] mask_i,
  input  logic [N_CLS-1:0] status_i,
  input  logic             clr_i,
  output logic             new_o,
  output logic             irq_o
);
  logic [N_CLS-1:0] new_vec, pend_q;

  // new = latched now, unmasked, and not already reported in status
  assign new_vec = live_i & ~mask_i & ~status_i;
  assign new_o   = |new_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= '0;
    else if (clr_i) pend_q <= '0;
    else            pend_q <= pend_q | new_vec;
  end

  // a later mask write suppresses the request without losing it
  assign irq_o = |(pend_q & ~mask_i);
endmodule

// File: rtl/fpx_exc_unit.sv
module fpx_exc_unit #(
  parameter int unsigned N_CLS = fpx_pkg::NUM_CLS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CLS-1:0] exc_set_i,
  input  logic             instr_start_i,
  input  logic             instr_end_i,
  input  logic             ctrl_we_i,
  input  logic [N_CLS-1:0] ctrl_mask_i,
  input  logic             status_clr_i,
  output logic [N_CLS-1:0] mask_o,
  output logic [N_CLS-1:0] status_o,
  output logic             unmasked_o,
  output logic             irq_o
);
  logic [N_CLS-1:0] live;

  fpx_latch_bank #(.N_CLS(N_CLS)) u_lat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (exc_set_i),
    .start_i (instr_start_i),
    .live_o  (live)
  );

  fpx_ctrl_status #(.N_CLS(N_CLS), .MASK_RST({N_CLS{1'b1}})) u_cs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (ctrl_we_i),
    .mask_i       (ctrl_mask_i),
    .commit_i     (instr_end_i),
    .commit_vec_i (live),
    .clr_i        (status_clr_i),
    .mask_o       (mask_o),
    .status_o     (status_o)
  );

  fpx_irq_gen #(.N_CLS(N_CLS)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .live_i   (live),
    .mask_i   (mask_o),
    .status_i (status_o),
    .clr_i    (status_clr_i),
    .new_o    (unmasked_o),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/fpx_exc_unit_chk.sv
module fpx_exc_unit_chk #(
  parameter int unsigned N_CLS = fpx_pkg::NUM_CLS
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctrl_we_i,
  input logic [N_CLS-1:0] ctrl_mask_i,
  input logic             status_clr_i,
  input logic [N_CLS-1:0] mask_o,
  input logic [N_CLS-1:0] status_o,
  input logic             unmasked_o,
  input logic             irq_o
);
  AST_UNM_RAISES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmasked_o && !status_clr_i && !ctrl_we_i |=> irq_o); // R9

  AST_IRQ_NEEDS_UNMASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_o != {N_CLS{1'b1}})); // R4

  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_clr_i |=> (status_o == '0) && !irq_o); // R8

  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_clr_i |=> ((status_o & $past(status_o)) == $past(status_o))); // R8

  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> (mask_o == $past(ctrl_mask_i))); // R10

  AST_UNM_IS_NEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmasked_o |-> ((~mask_o & ~status_o) != '0)); // R5
endmodule

bind fpx_exc_unit fpx_exc_unit_chk #(.N_CLS(N_CLS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctrl_we_i    (ctrl_we_i),
  .ctrl_mask_i  (ctrl_mask_i),
  .status_clr_i (status_clr_i),
  .mask_o       (mask_o),
  .status_o     (status_o),
  .unmasked_o   (unmasked_o),
  .irq_o        (irq_o)
);

// File: tb/fpx_exc_unit_test.sv
`timescale 1ns/1ps
module fpx_exc_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] set = '0;
  logic       start = 1'b0, fin = 1'b0, we = 1'b0, clr = 1'b0;
  logic [5:0] wmask = '0;
  logic [5:0] mask, status;
  logic       unm, irq;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fpx_exc_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .exc_set_i(set), .instr_start_i(start),
    .instr_end_i(fin), .ctrl_we_i(we), .ctrl_mask_i(wmask),
    .status_clr_i(clr), .mask_o(mask), .status_o(status),
    .unmasked_o(unm), .irq_o(irq)
  );

  // 0 mask, 1 status, 2 irq, 3 unmasked
  typedef struct { string req; int sel; logic [5:0] exp; } item_t;
  item_t sb[$];

  task automatic expect_out(input string req, input int sel, input logic [5:0] e);
    item_t it;
    it.req = req; it.sel = sel; it.exp = e;
    sb.push_back(it);
    #0;
  endtask

  initial begin
    forever begin
      item_t it;
      logic [5:0] act;
      wait (sb.size() != 0);
      it = sb.pop_front();
      case (it.sel)
        0: act = mask;
        1: act = status;
        2: act = {5'b0, irq};
        default: act = {5'b0, unm};
      endcase
      nchk++;
      if (act !== it.exp) begin
        nerr++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic drive(input logic [5:0] s, input logic st, input logic en,
                       input logic w, input logic [5:0] m, input logic c);
    set = s; start = st; fin = en; we = w; wmask = m; clr = c;
    #1;
  endtask

  task automatic tick();
    @(negedge clk); #1;
    set = '0; start = 0; fin = 0; we = 0; wmask = '0; clr = 0;
    #1;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    expect_out("R1", 0, 6'h3F);
    expect_out("R1", 1, 6'h00);
    expect_out("R1", 2, 6'h0);
    expect_out("R1", 3, 6'h0);
    rst_n = 1'b1;
    tick();

    // R10: unmask invalid (bit 0)
    drive(6'h00, 0, 0, 1, 6'h3E, 0); tick();
    expect_out("R10", 0, 6'h3E);

    // R4: masked denormal (bit 1)
    drive(6'h02, 0, 0, 0, 6'h00, 0);
    expect_out("R4", 3, 6'h0);
    tick();
    expect_out("R4", 2, 6'h0);

    // R3: unmasked invalid reported same cycle
    drive(6'h01, 0, 0, 0, 6'h00, 0);
    expect_out("R3", 3, 6'h1);
    tick();
    expect_out("R9", 2, 6'h1);
    expect_out("R3", 3, 6'h1);

    // R6, R2: commit both latches
    drive(6'h00, 0, 1, 0, 6'h00, 0); tick();
    expect_out("R6", 1, 6'h03);
    expect_out("R9", 2, 6'h1);
    expect_out("R5", 3, 6'h0);

    // start, then mask invalid: irq suppressed, status sticky
    drive(6'h00, 1, 0, 0, 6'h00, 0); tick();
    drive(6'h00, 0, 0, 1, 6'h3F, 0); tick();
    expect_out("R9", 2, 6'h0);
    expect_out("R8", 1, 6'h03);
    // unmask again: pending request returns
    drive(6'h00, 0, 0, 1, 6'h3E, 0); tick();
    expect_out("R9", 2, 6'h1);

    // R8, R9: clear
    drive(6'h00, 0, 0, 0, 6'h00, 1); tick();
    expect_out("R8", 1, 6'h00);
    expect_out("R9", 2, 6'h0);

    // R5: flag already in status suppresses a repeat event
    drive(6'h01, 0, 0, 0, 6'h00, 0); tick();
    drive(6'h00, 0, 1, 0, 6'h00, 0); tick();
    expect_out("R6", 1, 6'h01);
    drive(6'h00, 1, 0, 0, 6'h00, 0); tick();
    drive(6'h00, 0, 0, 0, 6'h00, 1); tick();
    expect_out("R9", 2, 6'h0);
    drive(6'h00, 0, 0, 0, 6'h00, 1); tick();
    // status now clear; make invalid flagged without irq path: commit via masked route
    drive(6'h00, 0, 0, 1, 6'h3F, 0); tick();
    drive(6'h01, 0, 1, 0, 6'h00, 0); tick();
    expect_out("R6", 1, 6'h01);
    drive(6'h00, 1, 0, 1, 6'h3E, 0); tick();
    drive(6'h01, 0, 0, 0, 6'h00, 0);
    expect_out("R5", 3, 6'h0);
    tick();
    expect_out("R5", 2, 6'h0);
    drive(6'h00, 1, 0, 0, 6'h00, 0); tick();
    drive(6'h00, 0, 0, 0, 6'h00, 1); tick();

    // R7: start drops overflow, coincident precision pulse survives
    drive(6'h08, 0, 0, 0, 6'h00, 0); tick();
    drive(6'h20, 1, 0, 0, 6'h00, 0); tick();
    drive(6'h00, 0, 1, 0, 6'h00, 0); tick();
    expect_out("R7", 1, 6'h20);

    // R8: clear wins over commit in the same cycle
    drive(6'h10, 0, 0, 0, 6'h00, 0);
    expect_out("R4", 3, 6'h0);
    tick();
    drive(6'h00, 0, 1, 0, 6'h00, 1); tick();
    expect_out("R8", 1, 6'h00);
    drive(6'h00, 0, 1, 0, 6'h00, 0); tick();
    expect_out("R2", 1, 6'h30);

    #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule